// File: doc/BRIEF.md
# Global-Shutter Exposure Sequencer

This block times one global-shutter exposure. A start strobe begins the sequence. The block first holds a global pixel reset for a programmed length. It then counts the main integration window. Inside that window it can raise one or two partial-reset pulses, one for each extra slope, so the sensor gets a multi-slope response. A single-clock end-of-exposure strobe closes the sequence, and the block returns to idle.

Every duration counts in the same unit, and a mode input picks that unit. The unit is either one system clock or one line period, marked by a line-tick pulse. All lengths are 16-bit values supplied from outside. The block captures them at start, so software can change them freely while an exposure runs.

States, all named in `exp_state_e`:

| State | Meaning |
|---|---|
| `ST_IDLE` | Waiting for a start strobe. |
| `ST_GRST` | Global reset pulse active. |
| `ST_INTEG` | Integration window, with the optional slope pulses. |
| `ST_DONE` | One-cycle end strobe. |

Transitions:

| Transition | Condition |
|---|---|
| IDLE→GRST | A start strobe arrives. |
| GRST→INTEG | The last reset unit is counted. |
| INTEG→DONE | The last integration unit is counted. |
| DONE→IDLE | Taken unconditionally. |

Top module: `exp_seq`

## Requirements
- R1: After reset, `pix_rst_o`, `slope_rst_o` and `eoi_o` are all low, and they stay low while idle.
- R2: A start strobe sampled in idle makes `pix_rst_o` rise on the next clock. It then stays high for exactly the programmed reset length, counted in units.
- R3: When `clk_units_i` is 1, every clock is one unit. When it is 0, a unit is a clock in which `line_tick_i` is high, and no phase ends except on such a clock.
- R4: Integration starts in the clock after the reset pulse ends and lasts the integration length in units. `eoi_o` is then high for exactly one clock, and the block is idle after it.
- R5: With `dual_en_i` set, `slope_rst_o` is high in each integration unit whose remaining count r (r counts down from the integration length to 1) satisfies dual_time < r <= dual_time + pulse_len. After the pulse, exactly dual_time units remain.
- R6: With `triple_en_i` set, the same rule applies using the triple time. The two pulses are OR-combined on `slope_rst_o`.
- R7: With both enables low, `slope_rst_o` stays low for the whole exposure.
- R8: A programmed length of zero is treated as one unit, for the reset, integration and pulse lengths.
- R9: A start strobe in any state other than idle, including the end-strobe clock, has no effect on timing and does not begin a new exposure.
- R10: The lengths, enables and unit mode are captured at the start strobe. Changes to them during an exposure have no effect on that exposure.
- R11: `slope_rst_o` is never high while `pix_rst_o` is high, and it is high only during integration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-exposure strobe |
| line_tick_i | input | 1 | One-clock pulse per line period |
| clk_units_i | input | 1 | 1: count clocks, 0: count line ticks |
| rst_len_i | input | 16 | Global reset length |
| pulse_len_i | input | 16 | Slope reset pulse length |
| tint_i | input | 16 | Main integration length |
| tint_dual_i | input | 16 | Time remaining after the dual-slope pulse |
| tint_triple_i | input | 16 | Time remaining after the triple-slope pulse |
| dual_en_i | input | 1 | Enable dual-slope pulse |
| triple_en_i | input | 1 | Enable triple-slope pulse |
| pix_rst_o | output | 1 | Global pixel reset |
| slope_rst_o | output | 1 | Partial (slope) reset pulse |
| eoi_o | output | 1 | End-of-integration strobe, one clock |

## Verification
The assertions check the following on every cycle:
- The reset pulse and the slope pulse never overlap.
- The reset pulse rises only after a start strobe.
- The reset pulse falls, and the end strobe rises, only on a counted unit.
- The end strobe lasts one clock and is followed by idle outputs.
- No slope pulse appears when both slopes are disabled.
- A start strobe during integration or during the end strobe never re-enters the reset state.

The exact pulse lengths need the bench's scenarios. These include pulse placement relative to the end of integration, clipping of a window that exceeds the integration length, zero-as-one handling, counting by line ticks, and immunity to configuration changes in mid-exposure.

// File: rtl/exp_seq_pkg.sv
package exp_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRST  = 2'd1,
        ST_INTEG = 2'd2,
        ST_DONE  = 2'd3
    } exp_state_e;

    localparam int NSLOPE = 2;
endpackage

// File: rtl/exp_unit_sel.sv
module exp_unit_sel (
    input  logic clk_units,
    input  logic line_tick,
    output logic unit
);
    always_comb begin
        unit = clk_units | line_tick;
    end
endmodule

// File: rtl/exp_slope_win.sv
module exp_slope_win #(
    parameter int W = 16
) (
    input  logic         active,
    input  logic         en,
    input  logic [W-1:0] rem,
    input  logic [W-1:0] gap,
    input  logic [W-1:0] len,
    output logic         win
);
    localparam int SW = W + 1;
    logic [SW-1:0] upper;

    always_comb begin
        upper = {1'b0, gap} + {1'b0, len};
        win   = active && en && (rem > gap) && ({1'b0, rem} <= upper);
    end
endmodule

// File: rtl/exp_seq.sv
module exp_seq #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic         line_tick_i,
    input  logic         clk_units_i,
    input  logic [W-1:0] rst_len_i,
    input  logic [W-1:0] pulse_len_i,
    input  logic [W-1:0] tint_i,
    input  logic [W-1:0] tint_dual_i,
    input  logic [W-1:0] tint_triple_i,
    input  logic         dual_en_i,
    input  logic         triple_en_i,
    output logic         pix_rst_o,
    output logic         slope_rst_o,
    output logic         eoi_o
);
    import exp_seq_pkg::*;

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    exp_state_e                   state_q, state_d;
    logic [W-1:0]                 cnt_q, cnt_d;
    logic [W-1:0]                 tint_q, plen_q;
    logic [NSLOPE-1:0][W-1:0]     gap_q;
    logic [NSLOPE-1:0]            slope_en_q;
    logic                         clk_units_q;
    logic                         unit;
    logic [NSLOPE-1:0]            win;

    function automatic logic [W-1:0] nz(input logic [W-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    exp_unit_sel u_unit (
        .clk_units (clk_units_q),
        .line_tick (line_tick_i),
        .unit      (unit)
    );

    for (genvar g = 0; g < NSLOPE; g++) begin : g_slope
        exp_slope_win #(.W(W)) u_win (
            .active (state_q == ST_INTEG),
            .en     (slope_en_q[g]),
            .rem    (cnt_q),
            .gap    (gap_q[g]),
            .len    (plen_q),
            .win    (win[g])
        );
    end

    // Next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_GRST;
                    cnt_d   = nz(rst_len_i);
                end
            end
            ST_GRST: begin
                if (unit) begin
                    if (cnt_q == ONE) begin
                        state_d = ST_INTEG;
                        cnt_d   = tint_q;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            end
            ST_INTEG: begin
                if (unit) begin
                    if (cnt_q == ONE) begin
                        state_d = ST_DONE;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register and configuration capture
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            tint_q      <= ONE;
            plen_q      <= ONE;
            gap_q       <= '0;
            slope_en_q  <= '0;
            clk_units_q <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (state_q == ST_IDLE && start_i) begin
                tint_q      <= nz(tint_i);
                plen_q      <= nz(pulse_len_i);
                gap_q[0]    <= tint_dual_i;
                gap_q[1]    <= tint_triple_i;
                slope_en_q  <= {triple_en_i, dual_en_i};
                clk_units_q <= clk_units_i;
            end
        end
    end

    // Outputs
    always_comb begin
        pix_rst_o   = (state_q == ST_GRST);
        slope_rst_o = |win;
        eoi_o       = (state_q == ST_DONE);
    end
endmodule

// File: rtl/exp_seq_chk.sv
module exp_seq_chk (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    start_i,
    input logic                    unit,
    input exp_seq_pkg::exp_state_e state_q,
    input logic [1:0]              slope_en_q,
    input logic                    pix_rst_o,
    input logic                    slope_rst_o,
    input logic                    eoi_o
);
    import exp_seq_pkg::*;

    p_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pix_rst_o && slope_rst_o));

    p_rise_after_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pix_rst_o) |-> $past(start_i));

    p_fall_on_unit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(pix_rst_o) |-> $past(unit));

    p_eoi_on_unit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(eoi_o) |-> $past(unit));

    p_eoi_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eoi_o |=> (!eoi_o && !pix_rst_o && !slope_rst_o));

    p_no_slope_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slope_en_q == 2'b00) |-> !slope_rst_o);

    p_ignore_integ_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_INTEG && start_i) |=> (state_q != ST_GRST));

    p_ignore_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_DONE && start_i) |=> (state_q == ST_IDLE));
endmodule

bind exp_seq exp_seq_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .unit        (unit),
    .state_q     (state_q),
    .slope_en_q  (slope_en_q),
    .pix_rst_o   (pix_rst_o),
    .slope_rst_o (slope_rst_o),
    .eoi_o       (eoi_o)
);

// File: tb/tb_exp_seq.sv
module tb_exp_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        tick = 1'b0;
    logic        cmode = 1'b1;
    logic [15:0] rlen = '0, plen = '0, tint = '0, tdual = '0, ttri = '0;
    logic        den = 1'b0, ten = 1'b0;
    logic        pix, slope, eoi;
    int          n_chk = 0, n_bad = 0, cyc = 0;

    always #4 clk = ~clk;

    exp_seq dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .line_tick_i(tick),
        .clk_units_i(cmode), .rst_len_i(rlen), .pulse_len_i(plen),
        .tint_i(tint), .tint_dual_i(tdual), .tint_triple_i(ttri),
        .dual_en_i(den), .triple_en_i(ten),
        .pix_rst_o(pix), .slope_rst_o(slope), .eoi_o(eoi)
    );

    typedef struct packed {
        int r; int t; int td; int tt; int pl; int de; int te;
        int e_rst; int e_part; int e_last; int e_eoi;
    } vec_t;

    // Clock mode; expected: reset cycles, slope cycles, index of last slope cycle, index of eoi
    localparam vec_t VEC [7] = '{
        '{3, 10, 0, 0, 0, 0, 0,  3, 0,  0, 14},
        '{2, 12, 4, 0, 3, 1, 0,  2, 3, 10, 15},
        '{0,  5, 0, 1, 2, 0, 1,  1, 2,  5,  7},
        '{1, 20, 8, 3, 2, 1, 1,  1, 4, 18, 22},
        '{2,  0, 0, 0, 0, 0, 0,  2, 0,  0,  4},
        '{1,  6, 2, 0, 0, 1, 0,  1, 1,  5,  8},
        '{1,  4, 2, 0, 5, 1, 0,  1, 2,  3,  6}
    };

    task automatic chk(input string req, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <150000", cyc);
            finish_run();
        end
    end

    // Clock-mode measurement. Start is driven at a falling edge; index i counts falling edges after it.
    task automatic measure(output int rc, output int pc, output int last, output int eat, output int ecount);
        rc = 0; pc = 0; last = 0; eat = 0; ecount = 0;
        start = 1'b1;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (pix) rc++;
            if (slope) begin pc++; last = i; end
            if (eoi) begin ecount++; if (eat == 0) eat = i; end
        end
    endtask

    initial begin
        int rc, pc, last, eat, ecount, ticks, prev_tick, pix_seen, pix_done;
        repeat (3) @(negedge clk);
        chk("R1 pix after reset", pix, 0);
        chk("R1 slope after reset", slope, 0);
        chk("R1 eoi after reset", eoi, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 idle outputs", {29'd0, pix, slope, eoi}, 0);

        // Table walk: R2 R4 R5 R6 R7 R8
        foreach (VEC[k]) begin
            rlen = VEC[k].r[15:0]; tint = VEC[k].t[15:0];
            tdual = VEC[k].td[15:0]; ttri = VEC[k].tt[15:0];
            plen = VEC[k].pl[15:0]; den = VEC[k].de[0]; ten = VEC[k].te[0];
            cmode = 1'b1;
            measure(rc, pc, last, eat, ecount);
            chk($sformatf("R2/R8 vec%0d reset cycles", k), rc, VEC[k].e_rst);
            chk($sformatf("R5/R6/R7 vec%0d slope cycles", k), pc, VEC[k].e_part);
            chk($sformatf("R5/R6 vec%0d last slope index", k), last, VEC[k].e_last);
            chk($sformatf("R4/R8 vec%0d eoi index", k), eat, VEC[k].e_eoi);
            chk($sformatf("R4 vec%0d single eoi", k), ecount, 1);
        end

        // R3 line mode: reset 2 lines, integrate 3 lines, tick every third clock
        cmode = 1'b0; rlen = 16'd2; tint = 16'd3; den = 1'b0; ten = 1'b0;
        tick = 1'b0; start = 1'b1;
        ticks = 0; prev_tick = 0; pix_seen = 0; pix_done = 0; ecount = 0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (pix) pix_seen = 1;
            if (pix_seen && !pix && !pix_done) begin
                pix_done = 1;
                chk("R3 reset ends after 2 ticks", ticks, 2);
                chk("R3 reset ends on tick clock", prev_tick, 1);
            end
            if (eoi) begin
                ecount++;
                chk("R3 eoi after 5 ticks", ticks, 5);
                chk("R3 eoi on tick clock", prev_tick, 1);
            end
            prev_tick = (i % 3 == 2) ? 1 : 0;
            tick = prev_tick[0];
            if (prev_tick == 1) ticks++;
        end
        tick = 1'b0;
        chk("R3 line mode single eoi", ecount, 1);

        // R10 + R9: capture at start, restarts ignored
        cmode = 1'b1; rlen = 16'd3; tint = 16'd10; den = 1'b0; ten = 1'b0;
        start = 1'b1; eat = 0; ecount = 0; rc = 0;
        for (int i = 1; i <= 30; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (pix) rc++;
            if (eoi) begin ecount++; if (eat == 0) eat = i; end
            if (i == 2) begin tint = 16'd2; cmode = 1'b0; rlen = 16'd9; end
            if (i == 6) start = 1'b1;
            if (i == 13) start = 1'b1;
        end
        chk("R10 eoi index with mid-run changes", eat, 14);
        chk("R9 reset cycles with restarts", rc, 3);
        chk("R9 single eoi with restarts", ecount, 1);

        // R1: after the sequence, idle stays quiet
        repeat (5) @(negedge clk);
        chk("R1 idle after exposure", {30'd0, pix, eoi}, 0);

        finish_run();
    end
endmodule